// File: doc/BRIEF.md
# Masked Associative Search Array

This block is a small content-addressable store of `WORDS` entries, each `WIDTH` bits wide. It does not look data up by address. A search compares one operand against every stored entry in the same clock cycle and captures one hit flag per entry into a registered match vector.

A global column mask decides which bit positions take part in the comparison. Columns whose mask bit is 0 count as equal whatever the data is. Because of this, a mask of all zeros makes every entry report a hit.

Entries are loaded one at a time through a write port that takes an index. The operand and the mask each sit in their own register, loaded by separate strobes. A search strobe samples the registered operand, the registered mask and the current contents, then updates the match vector on that edge.

Top module: `masked_cam`

## Requirements
- R1: On reset, every stored entry, the operand register, the mask register and the match vector clear to zero.
- R2: The match vector changes only on a clock edge where `srch_go` is high, and holds its value on every other edge.
- R3: A column whose mask bit is 1 takes part in the comparison. A column whose mask bit is 0 counts as equal for any operand bit and stored bit.
- R4: Bit i of `hit_vec` is set after a search exactly when entry i equals the operand in every column whose mask bit is 1.
- R5: When the mask register is all zeros, a search sets every bit of `hit_vec` to 1, whatever the stored contents are.
- R6: A search uses the operand and mask held before its edge. A load of either register on the same edge first takes effect in the next search.
- R7: A write on the same edge as a search does not change that search's result. The new contents take part from the next search onward.
- R8: A write whose index is `WORDS` or larger leaves every stored entry unchanged.
- R9: A write with `wr_en` high and index i below `WORDS` replaces entry i with `wr_word` and touches no other entry.
- R10: With operand 1010, mask 1100 and entries 1001, 1101 and 1011 at indices 0, 1 and 2 (4-bit columns), bits 0 to 2 of `hit_vec` are 1, 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the entry store |
| wr_idx | input | IDX_W | Entry index to write. IDX_W is clog2(WORDS)+1, so indices that are out of range can be presented |
| wr_word | input | WIDTH | Data to store |
| opnd_ld | input | 1 | Load strobe for the operand register |
| opnd_in | input | WIDTH | New operand value |
| mask_ld | input | 1 | Load strobe for the mask register |
| mask_in | input | WIDTH | New column mask value |
| srch_go | input | 1 | Search strobe |
| hit_vec | output | WORDS | Registered match vector. Bit i belongs to entry i |

## Verification
Random stimulus mixes writes, loads and searches. Operands are often copied from a stored entry, and masks range from sparse to dense, so that hits, partial hits and misses all occur.

Directed cases isolate specific behaviours:
- The worked 4-column example.
- An all-zero mask over differing contents, which shows that masked columns are ignored.
- A full mask over zeroed storage, which shows the reset contents.
- A write and a search on the same edge, and an operand load and a search on the same edge, which separate old values from new ones.
- Out-of-range writes, which would show up as a stray hit if they reached the store.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int unsigned CAM_DEF_WORDS = 8;
    localparam int unsigned CAM_DEF_WIDTH = 8;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int unsigned WORDS = 8,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned IDX_W = $clog2(WORDS) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WIDTH-1:0]              wr_word,
    output logic [WORDS-1:0][WIDTH-1:0]   ent_q
);
    localparam int unsigned SEL_W = $clog2(WORDS);

    logic [WORDS-1:0][WIDTH-1:0] ent_d;
    logic                        in_range;

    always_comb begin
        in_range = (wr_idx < IDX_W'(WORDS));
        ent_d    = ent_q;
        if (wr_en && in_range) begin
            ent_d[wr_idx[SEL_W-1:0]] = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    // R8: an out-of-range index must leave the store untouched
    a_r8_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> $stable(ent_q));

    for (genvar g = 0; g < WORDS; g++) begin : g_chk
        // R9: the addressed entry takes the written word
        a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (ent_q[g] == $past(wr_word)));
        // R9: entries that are not addressed keep their contents
        a_r9_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(ent_q[g]));
    end
endmodule

// File: rtl/cam_opreg.sv
module cam_opreg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opnd_ld,
    input  logic [WIDTH-1:0] opnd_in,
    input  logic             mask_ld,
    input  logic [WIDTH-1:0] mask_in,
    output logic [WIDTH-1:0] opnd_q,
    output logic [WIDTH-1:0] mask_q
);
    typedef struct packed {
        logic [WIDTH-1:0] opnd;
        logic [WIDTH-1:0] mask;
    } ops_t;

    ops_t ops_d, ops_q;

    always_comb begin
        ops_d = ops_q;
        if (opnd_ld) ops_d.opnd = opnd_in;
        if (mask_ld) ops_d.mask = mask_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ops_q <= '0;
        else        ops_q <= ops_d;
    end

    assign opnd_q = ops_q.opnd;
    assign mask_q = ops_q.mask;

    // R6: without a load strobe the operand and the mask hold
    a_r6_opnd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_ld |=> $stable(opnd_q));
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_ld |=> $stable(mask_q));
endmodule

// File: rtl/cam_match_row.sv
module cam_match_row #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] entry,
    output logic             hit
);
    logic [WIDTH-1:0] col_ok;

    for (genvar j = 0; j < WIDTH; j++) begin : g_col
        // equal bits, or a column that the mask leaves out
        assign col_ok[j] = ~(opnd[j] ^ entry[j]) | ~mask[j];
    end

    assign hit = &col_ok;
endmodule

// File: rtl/cam_hit_reg.sv
module cam_hit_reg #(
    parameter int unsigned WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_go,
    input  logic [WORDS-1:0] hit_raw,
    output logic [WORDS-1:0] hit_q
);
    logic [WORDS-1:0] hit_d;

    always_comb begin
        hit_d = hit_q;
        if (srch_go) hit_d = hit_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= hit_d;
    end

    // R2: the match vector moves only on a search edge
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_go |=> $stable(hit_q));
endmodule

// File: rtl/masked_cam.sv
module masked_cam
    import cam_pkg::*;
#(
    parameter int unsigned WORDS = CAM_DEF_WORDS,
    parameter int unsigned WIDTH = CAM_DEF_WIDTH,
    parameter int unsigned IDX_W = $clog2(WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_word,
    input  logic             opnd_ld,
    input  logic [WIDTH-1:0] opnd_in,
    input  logic             mask_ld,
    input  logic [WIDTH-1:0] mask_in,
    input  logic             srch_go,
    output logic [WORDS-1:0] hit_vec
);
    logic [WORDS-1:0][WIDTH-1:0] ent_q;
    logic [WIDTH-1:0]            opnd_q;
    logic [WIDTH-1:0]            mask_q;
    logic [WORDS-1:0]            hit_raw;

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .ent_q(ent_q)
    );

    cam_opreg #(.WIDTH(WIDTH)) u_ops (
        .clk(clk), .rst_n(rst_n), .opnd_ld(opnd_ld), .opnd_in(opnd_in),
        .mask_ld(mask_ld), .mask_in(mask_in), .opnd_q(opnd_q), .mask_q(mask_q)
    );

    for (genvar i = 0; i < WORDS; i++) begin : g_row
        cam_match_row #(.WIDTH(WIDTH)) u_row (
            .opnd(opnd_q), .mask(mask_q), .entry(ent_q[i]), .hit(hit_raw[i])
        );
    end

    cam_hit_reg #(.WORDS(WORDS)) u_hits (
        .clk(clk), .rst_n(rst_n), .srch_go(srch_go), .hit_raw(hit_raw),
        .hit_q(hit_vec)
    );

    // R5: an empty mask makes every entry hit
    a_r5_empty_mask_all_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_go && mask_q == '0) |=> (&hit_vec));

    // R4: an entry equal to the operand always hits, whatever the mask
    for (genvar i = 0; i < WORDS; i++) begin : g_eq
        a_r4_exact_hits: assert property (@(posedge clk) disable iff (!rst_n)
            (srch_go && ent_q[i] == opnd_q) |=> hit_vec[i]);
    end
endmodule

// File: tb/masked_cam_tb.sv
module masked_cam_tb;
    localparam int unsigned WORDS  = 8;
    localparam int unsigned WIDTH  = 8;
    localparam int unsigned IDX_W  = $clog2(WORDS) + 1;
    localparam time         CLK_PERIOD = 10ns;
    localparam int          WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [WIDTH-1:0] wr_word = '0;
    logic             opnd_ld = 1'b0;
    logic [WIDTH-1:0] opnd_in = '0;
    logic             mask_ld = 1'b0;
    logic [WIDTH-1:0] mask_in = '0;
    logic             srch_go = 1'b0;
    logic [WORDS-1:0] hit_vec;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [WIDTH-1:0] m_ent [WORDS];
    logic [WIDTH-1:0] m_opnd, m_mask;
    logic [WORDS-1:0] m_hit;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_cam #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .opnd_ld(opnd_ld), .opnd_in(opnd_in),
        .mask_ld(mask_ld), .mask_in(mask_in), .srch_go(srch_go),
        .hit_vec(hit_vec)
    );

    function automatic logic [WORDS-1:0] exp_hits();
        logic [WORDS-1:0] r;
        for (int i = 0; i < WORDS; i++) begin
            r[i] = ((m_ent[i] & m_mask) == (m_opnd & m_mask));
        end
        return r;
    endfunction

    task automatic check(input logic [WORDS-1:0] act, input logic [WORDS-1:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: hit_vec=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [IDX_W-1:0] wi,
                        input logic [WIDTH-1:0] wd, input logic ol,
                        input logic [WIDTH-1:0] od, input logic ml,
                        input logic [WIDTH-1:0] md, input logic sg,
                        input string req);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_word = wd;
        opnd_ld = ol; opnd_in = od; mask_ld = ml; mask_in = md; srch_go = sg;
        @(posedge clk);
        #1;
        if (sg) m_hit = exp_hits();
        if (ol) m_opnd = od;
        if (ml) m_mask = md;
        if (we && wi < IDX_W'(WORDS)) m_ent[wi[IDX_W-2:0]] = wd;
        check(hit_vec, m_hit, req);
    endtask

    task automatic wr(input int i, input logic [WIDTH-1:0] d, input string req);
        step(1'b1, IDX_W'(i), d, 1'b0, '0, 1'b0, '0, 1'b0, req);
    endtask

    task automatic srch(input string req);
        step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1, req);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < WORDS; i++) m_ent[i] = '0;
        m_opnd = '0; m_mask = '0; m_hit = '0;
        repeat (3) @(posedge clk);
        #1;
        check(hit_vec, '0, "R1 reset match vector");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: full mask over cleared storage and a zero operand -> all entries hit
        step(1'b0, '0, '0, 1'b0, '0, 1'b1, '1, 1'b0, "R1 mask load");
        srch("R1 cleared entries match zero operand");
        check(hit_vec, '1, "R1 all hit after reset");

        // R8: out-of-range writes must not create a hit
        for (int k = WORDS; k < 2 * WORDS; k++) wr(k, 8'h5A, "R8 oob write");
        step(1'b0, '0, '0, 1'b1, 8'h5A, 1'b0, '0, 1'b0, "R8 operand load");
        srch("R8 oob write ignored");
        check(hit_vec, '0, "R8 no hit on oob pattern");

        // R10: worked example on the low four columns, upper columns zero
        wr(0, 8'h09, "R9 write e0"); wr(1, 8'h0D, "R9 write e1"); wr(2, 8'h0B, "R9 write e2");
        step(1'b0, '0, '0, 1'b1, 8'h0A, 1'b1, 8'h0C, 1'b0, "R10 load");
        srch("R10 worked example");
        check(hit_vec[2:0], 3'b101, "R10 flags 1,0,1");

        // R2: idle edges hold the vector
        step(1'b0, '0, '0, 1'b1, 8'hFF, 1'b1, 8'h00, 1'b0, "R2 hold on idle");
        check(hit_vec[2:0], 3'b101, "R2 held");

        // R5 / R3: empty mask -> every entry hits despite differing contents
        srch("R5 empty mask");
        check(hit_vec, '1, "R5 all ones");

        // R6: loads on the search edge are not seen by that search
        step(1'b0, '0, '0, 1'b1, 8'h0D, 1'b1, 8'hFF, 1'b1, "R6 same-edge load");
        check(hit_vec, '1, "R6 old mask used");
        srch("R6 new values used next");
        check(hit_vec, 8'b0000_0010, "R6 only entry 1 hits");

        // R7: write on the search edge is not seen by that search
        step(1'b1, IDX_W'(5), 8'h0D, 1'b0, '0, 1'b0, '0, 1'b1, "R7 same-edge write");
        check(hit_vec, 8'b0000_0010, "R7 old contents used");
        srch("R7 new contents next search");
        check(hit_vec, 8'b0010_0010, "R7 entry 5 now hits");

        // R3: single-column masks
        for (int c = 0; c < WIDTH; c++) begin
            step(1'b0, '0, '0, 1'b0, '0, 1'b1, WIDTH'(1) << c, 1'b0, "R3 mask col");
            srch("R3 single column");
        end

        // Random mix, R4 / R9 / R2 / R6 / R7
        for (int n = 0; n < 3000; n++) begin
            logic we, ol, ml, sg;
            logic [IDX_W-1:0] wi;
            logic [WIDTH-1:0] wd, od, md;
            we = ($urandom % 3) == 0;
            wi = IDX_W'($urandom % (WORDS + 2));
            wd = WIDTH'($urandom);
            ol = ($urandom % 3) == 0;
            od = (($urandom % 2) == 0) ? m_ent[$urandom % WORDS] : WIDTH'($urandom);
            ml = ($urandom % 4) == 0;
            case ($urandom % 4)
                0: md = '0;
                1: md = '1;
                2: md = WIDTH'($urandom) & WIDTH'($urandom);
                default: md = WIDTH'($urandom);
            endcase
            sg = ($urandom % 2) == 0;
            step(we, wi, wd, ol, od, ml, md, sg, "R4 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule